// File: doc/BRIEF.md
# Sampling ADC Interface Emulator

A synthesizable digital model of a six-channel, 12-bit successive-approximation converter with a host strobe interface. A host writes a control byte with a write strobe while chip select is low; the byte picks an input channel and carries range, polarity, acquisition-mode and clock/power-mode bits. If the byte asks for an internally timed conversion on a legal channel, the block samples that channel's 12-bit digital input, counts out a fixed conversion time and then pulls its active-low done flag low.

The host takes the result by pulling the read strobe low with chip select. This drives the held result onto the data output and releases the done flag on the next clock. A control-byte write that arrives while a conversion is running aborts it and starts a new sampling cycle. The strobes are sampled on the block clock, and that same clock times the conversion. This lets the block stand in for a real converter in a digital acquisition loop, for example a controller that keeps writing commands and reading results into a buffer.

Top module: `adc_emulator`

## Requirements
- R1: Control byte fields: bits [2:0] channel code, bit 3 range, bit 4 polarity, bit 5 acquisition mode, bits [7:6] clock/power mode. A write is accepted on the clock edge where wr_n is seen high after being low on the previous edge while cs_n is low. After an accepted write, mode_bits shows byte bits [7:3] (mode_bits[2] = acquisition mode).
- R2: An accepted write with acquisition mode 0 and channel code 0..5 starts a conversion and drives done_n high. done_n stays high for the next 11 edges and falls on the 12th edge after the accepting edge.
- R3: The result equals the selected channel's input as sampled on the first edge after the accepting edge. Later changes of that input do not alter it.
- R4: A write with channel code 6 or 7 is ignored entirely. mode_bits is unchanged, no conversion starts, and a running conversion completes on time with its own channel.
- R5: An accepted write with acquisition mode 1 latches mode_bits, cancels any running conversion and starts none. done_n stays high.
- R6: A valid start during a conversion restarts it. done_n falls 12 edges after the new write, and the result comes from the new channel.
- R7: While cs_n and rd_n are both low, data_out shows the last completed result; otherwise data_out is 0. done_n returns high on the first edge with the read active, unless a conversion completes on that edge.
- R8: The result is held until the next conversion completes. Repeated reads, and reads during a later conversion, return the previous result.
- R9: A rising write strobe with cs_n high is ignored.
- R10: Reset drives done_n high, clears any conversion, and zeroes the result and mode_bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; times strobes and conversion |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; its rising edge accepts the byte |
| rd_n | input | 1 | Active-low read strobe |
| ctrl_byte | input | 8 | Control byte written by the host |
| chan_data | input | 72 | Six 12-bit channel values, channel i at bits [12i+11:12i] |
| data_out | output | 12 | Result while a read is active, else 0 |
| done_n | output | 1 | Active-low conversion-complete flag |
| mode_bits | output | 5 | Latched control byte bits [7:3] |

## Verification
The bench aims at the exact edge on which done_n falls. A counter that is off by one would make the flag fall on the 11th or 13th edge, and the bench checks both neighbours. It restarts a conversion mid-flight and writes illegal channel codes mid-flight. A design that ignored the restart would finish early with the old channel, and one that honoured the illegal code would cancel or retarget the running conversion. It also changes the selected input after sampling, reads during a later conversion, and strobes with chip select high. These catch a design that tracks its input live, overwrites the result early or ignores chip select.

// File: rtl/adc_emulator_pkg.sv
package adc_emulator_pkg;

  localparam int CTRL_W    = 8;
  localparam int CHAN_LSB  = 0;
  localparam int CHAN_W    = 3;
  localparam int ACQ_BIT   = 5;
  localparam int MODE_LSB  = 3;
  localparam int MODE_W    = CTRL_W - MODE_LSB;

  function automatic logic [CHAN_W-1:0] chan_code(input logic [CTRL_W-1:0] b);
    return b[CHAN_LSB +: CHAN_W];
  endfunction

  function automatic logic chan_legal(input logic [CHAN_W-1:0] code, input int n_ch);
    return int'(code) < n_ch;
  endfunction

  function automatic logic ext_acq(input logic [CTRL_W-1:0] b);
    return b[ACQ_BIT];
  endfunction

  function automatic logic [MODE_W-1:0] mode_field(input logic [CTRL_W-1:0] b);
    return b[MODE_LSB +: MODE_W];
  endfunction

endpackage

// File: rtl/adc_strobe_edge.sv
module adc_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  input  logic rd_n,
  output logic wr_accept,
  output logic rd_active
);
  logic wr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= wr_n;
  end

  assign wr_accept = wr_n & ~wr_prev & ~cs_n;
  assign rd_active = ~rd_n & ~cs_n;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic busy,
  output logic first_cyc,
  output logic conv_end
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          quiet;

  assign quiet     = ~start & ~cancel;
  assign first_cyc = busy & (cnt == '0) & quiet;
  assign conv_end  = busy & (cnt == LAST) & quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (cancel) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_chan_sampler.sv
module adc_chan_sampler #(
  parameter int N_CH  = 6,
  parameter int RES   = 12,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH*RES-1:0] chan_data,
  input  logic [SEL_W-1:0]  sel,
  input  logic              sample_en,
  output logic [RES-1:0]    held
);
  logic [RES-1:0] slice [N_CH];
  logic [RES-1:0] picked;

  for (genvar g = 0; g < N_CH; g++) begin : g_slice
    assign slice[g] = chan_data[g*RES +: RES];
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (sel == SEL_W'(i)) picked = slice[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held <= '0;
    else if (sample_en) held <= picked;
  end
endmodule

// File: rtl/adc_emulator.sv
module adc_emulator
  import adc_emulator_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int RES    = 12,
  parameter int CYCLES = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic                rd_n,
  input  logic [7:0]          ctrl_byte,
  input  logic [N_CH*RES-1:0] chan_data,
  output logic [RES-1:0]      data_out,
  output logic                done_n,
  output logic [4:0]          mode_bits
);
  // named internal events, also watched by the checker
  logic              wr_acc, rd_act, chan_ok, start, cancel;
  logic              busy, first_cyc, conv_end;
  logic [CHAN_W-1:0] chan_q;
  logic [RES-1:0]    held, result_q;

  adc_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .wr_accept(wr_acc), .rd_active(rd_act)
  );

  assign chan_ok = chan_legal(chan_code(ctrl_byte), N_CH);
  assign start   = wr_acc & chan_ok & ~ext_acq(ctrl_byte);
  assign cancel  = wr_acc & chan_ok &  ext_acq(ctrl_byte);

  adc_conv_timer #(.CYCLES(CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
    .busy(busy), .first_cyc(first_cyc), .conv_end(conv_end)
  );

  adc_chan_sampler #(.N_CH(N_CH), .RES(RES), .SEL_W(CHAN_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .chan_data(chan_data), .sel(chan_q),
    .sample_en(first_cyc), .held(held)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q    <= '0;
      mode_bits <= '0;
    end else if (wr_acc && chan_ok) begin
      chan_q    <= chan_code(ctrl_byte);
      mode_bits <= mode_field(ctrl_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_n   <= 1'b1;
      result_q <= '0;
    end else if (conv_end) begin
      done_n   <= 1'b0;
      result_q <= held;
    end else if (start || cancel || rd_act) begin
      done_n   <= 1'b1;
    end
  end

  assign data_out = rd_act ? result_q : '0;
endmodule

// File: rtl/adc_emulator_chk.sv
module adc_emulator_chk #(
  parameter int RES = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     ctrl_byte,
  input logic           wr_acc,
  input logic           rd_act,
  input logic           start,
  input logic           cancel,
  input logic           busy,
  input logic           conv_end,
  input logic           done_n,
  input logic [RES-1:0] data_out
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (done_n && !busy)); // R10

  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ctrl_byte[2:0] > 3'd5) |-> (!start && !cancel)); // R4

  AST_EXT_ACQ_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ctrl_byte[5]) |-> !start); // R5

  AST_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && done_n)); // R6

  AST_DONE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_n) |-> $past(conv_end)); // R2

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && !conv_end) |=> done_n); // R7

  AST_HELD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && $past(rd_act) && !$past(conv_end)) |-> $stable(data_out)); // R8
endmodule

bind adc_emulator adc_emulator_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .wr_acc(wr_acc),
  .rd_act(rd_act), .start(start), .cancel(cancel), .busy(busy),
  .conv_end(conv_end), .done_n(done_n), .data_out(data_out)
);

// File: tb/adc_emulator_test.sv
module adc_emulator_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int RW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] ctrl_byte = '0;
  logic [NCH*RW-1:0] chan_data;
  logic [RW-1:0] data_out;
  logic done_n;
  logic [4:0] mode_bits;

  int checks = 0, failures = 0;
  logic [4:0] exp_mode = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_emulator uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .ctrl_byte(ctrl_byte), .chan_data(chan_data), .data_out(data_out),
    .done_n(done_n), .mode_bits(mode_bits)
  );

  function automatic logic [RW-1:0] chan_val(input int i);
    return RW'(12'h0A5 + 12'h2C3 * i);
  endfunction

  // {ctrl byte, expect start}
  localparam logic [8:0] VEC [9] = '{
    {8'h00, 1'b1}, {8'h09, 1'b1}, {8'h12, 1'b1}, {8'h03, 1'b1},
    {8'hC4, 1'b1}, {8'h05, 1'b1}, {8'h06, 1'b0}, {8'h27, 1'b0},
    {8'h21, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns at the negedge just after the accepting edge
  task automatic write_byte(input logic [7:0] b, input logic sel);
    @(negedge clk); cs_n = ~sel; wr_n = 1'b0; ctrl_byte = b;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    if (sel && (int'(b[2:0]) < NCH)) exp_mode = b[7:3];
  endtask

  task automatic read_check(input logic [RW-1:0] exp, input string tag);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
    chk(data_out == exp, tag, data_out, exp);
    @(negedge clk);
    chk(done_n == 1'b1, "R7 done_n released by read", done_n, 1);
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  // after write_byte: done high at 11 edges, low at 12
  task automatic expect_done_timing(input string tag);
    tick(11);
    chk(done_n == 1'b1, {tag, " done_n high before 12th edge"}, done_n, 1);
    tick(1);
    chk(done_n == 1'b0, {tag, " done_n low at 12th edge"}, done_n, 0);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) chan_data[i*RW +: RW] = chan_val(i);
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3); #1;
    // R10 reset state
    chk(done_n == 1'b1, "R10 done_n in reset", done_n, 1);
    chk(mode_bits == 5'd0, "R10 mode_bits in reset", mode_bits, 0);
    rst_n = 1'b1;
    tick(2);
    read_check('0, "R10 result zero after reset");

    // table walk: R1 R2 R3 R4 R5
    for (int v = 0; v < 9; v++) begin
      logic [7:0] b;
      logic st;
      b  = VEC[v][8:1];
      st = VEC[v][0];
      write_byte(b, 1'b1);
      chk(mode_bits == exp_mode, "R1 mode_bits latch", mode_bits, exp_mode);
      if (st) begin
        expect_done_timing("R2");
        read_check(chan_val(int'(b[2:0])), "R3 result from selected channel");
      end else begin
        tick(14);
        chk(done_n == 1'b1, "R4/R5 no conversion started", done_n, 1);
      end
    end

    // R6 restart mid-conversion
    write_byte(8'h01, 1'b1);
    tick(5);
    write_byte(8'h02, 1'b1);
    expect_done_timing("R6");
    read_check(chan_val(2), "R6 result from new channel");

    // R4 illegal code during conversion leaves it running
    write_byte(8'h03, 1'b1);
    tick(2);
    write_byte(8'h07, 1'b1);
    tick(8);
    chk(done_n == 1'b0, "R4 running conversion finished on time", done_n, 0);
    chk(mode_bits == 5'd0, "R4 mode_bits unchanged", mode_bits, 0);
    read_check(chan_val(3), "R4 result kept old channel");

    // R5 external acquisition cancels running conversion
    write_byte(8'h04, 1'b1);
    tick(3);
    write_byte(8'h24, 1'b1);
    chk(mode_bits == 5'b00100, "R5 mode_bits latched", mode_bits, 5'b00100);
    tick(15);
    chk(done_n == 1'b1, "R5 cancelled conversion never completes", done_n, 1);

    // R3 input change after sampling
    write_byte(8'h02, 1'b1);
    tick(2);
    chan_data[2*RW +: RW] = 12'hFFF;
    tick(10);
    chk(done_n == 1'b0, "R3 done", done_n, 0);
    read_check(chan_val(2), "R3 sampled value kept");
    chan_data[2*RW +: RW] = chan_val(2);

    // R8 held result: repeat read and read during later conversion
    read_check(chan_val(2), "R8 repeated read");
    write_byte(8'h05, 1'b1);
    tick(3);
    read_check(chan_val(2), "R8 read during conversion");
    tick(9);
    read_check(chan_val(5), "R8 replaced after completion");

    // R9 write with cs_n high ignored
    write_byte(8'h01, 1'b0);
    tick(14);
    chk(done_n == 1'b1, "R9 no start without chip select", done_n, 1);
    read_check(chan_val(5), "R9 result unchanged");

    // R10 reset mid-conversion
    write_byte(8'hC1, 1'b1);
    tick(4);
    rst_n = 1'b0;
    tick(1); #1;
    chk(mode_bits == 5'd0, "R10 mode_bits cleared", mode_bits, 0);
    rst_n = 1'b1;
    exp_mode = '0;
    tick(15);
    chk(done_n == 1'b1, "R10 conversion cleared by reset", done_n, 1);
    read_check('0, "R10 result cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule